// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of an SDRAM interface and takes the memory from power-up to normal operation. A single start pulse launches a fixed recipe: a long stabilisation wait, a no-operation command, a precharge of all banks, a fixed number of auto-refresh rounds and a mode-register load. The controller then drops back to its normal command mode and raises a refresh-enable output, which hands the memory over to the periodic refresh logic. All waits are counted in clock cycles. They are derived from parameters for the clock frequency, the stabilisation time in microseconds, the precharge and refresh recovery times in nanoseconds, and plain cycle counts.

Each command other than normal is broadcast to the populated rows only. One row is addressed per cycle, in ascending row order, with a one-hot row select. Unpopulated rows receive nothing. The mode-register word is built from the CAS latency, burst length, burst type and write-burst inputs, which are latched when a start is accepted. A start is refused when the CAS latency is anything other than 2 or 3, and this refusal raises an error flag. A start that arrives while a sequence is in flight is discarded.

Top module: `sdram_init_seq`

## Requirements
- R1: `cmdCode` only ever carries 0 (normal), 1 (no-op), 2 (precharge all), 3 (mode-register set) or 4 (auto-refresh); values 5, 6 and 7 never appear.
- R2: After an accepted start, no command is issued until at least STAB_US × CLK_MHZ clock cycles have elapsed.
- R3: Each populated row receives, in order, one no-op, one precharge-all, exactly REF_ROUNDS (default 8) auto-refresh commands and one mode-register set. Every issue carries a one-hot `rowSel`, and each command is issued to the rows in ascending index order, one row per cycle.
- R4: On any row, the gap to its next command is at least NOP_CYC cycles after the no-op, at least ceil(TRP_NS × CLK_MHZ / 1000) cycles after the precharge, and at least ceil(TRC_NS × CLK_MHZ / 1000) cycles after an auto-refresh. `done` rises at least MRS_CYC cycles after the last mode-register set.
- R5: `modeWord` is built as follows: bits [2:0] hold the burst length and bit 3 the burst type. Bits [6:4] hold the CAS latency code (2 or 3). Bits [8:7] are zero. Bit 9 is the write-burst mode (1 = single access, 0 = programmed length). Bits [11:10] are zero.
- R6: Returning to normal mode issues no command (`cmdValid` is never high with code 0). `refreshEn` and `done` rise only after `cmdCode` has returned to 0. They stay high with no further commands until the next accepted start, which clears them.
- R7: A row whose `rowPresent` bit is 0 receives no command at all.
- R8: A start pulse during a running sequence has no effect: the command counts, the total duration and `cfgError` are the same as in an undisturbed run.
- R9: A start with `casLat` outside {2, 3} sets `cfgError` in the next cycle and does not begin a sequence. The next accepted start clears `cfgError`.
- R10: After reset, `cmdCode` is 0 and `cmdValid`, `rowSel`, `refreshEn`, `done` and `cfgError` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startPulse | input | 1 | Begin the power-up sequence (one cycle) |
| casLat | input | 3 | Requested CAS latency, 2 or 3 |
| burstLen | input | 3 | Burst-length code for the mode word |
| burstType | input | 1 | Burst-type bit for the mode word |
| singleWrite | input | 1 | Write-burst mode: 1 = single-location writes |
| rowPresent | input | NUM_ROWS | One bit per row, 1 = populated |
| cmdCode | output | 3 | Current command mode code |
| cmdValid | output | 1 | A command is issued this cycle to the row in `rowSel` |
| rowSel | output | NUM_ROWS | One-hot row being addressed, zero when idle |
| modeWord | output | 12 | Mode-register word for the mode-register set |
| refreshEn | output | 1 | Periodic refresh may run |
| done | output | 1 | Sequence complete |
| cfgError | output | 1 | Last start was refused for an illegal CAS latency |

## Verification
The following properties are checked on every cycle:
- the command code never takes a reserved value;
- every issue has a one-hot row select that points only at a populated row;
- the normal code is never issued as a command;
- refresh-enable coincides with a quiet, normal-mode bus;
- the mode word is legal whenever a mode-register set goes out;
- the global gap between the end of one step and the start of the next respects that step's recovery time.

Other behaviour can only be shown by the bench scenarios. These cover the full per-row order and the exact count of refresh rounds, the per-row spacing, the stabilisation delay and the silence on empty rows. They also show that a start during a run is ignored, by comparing the run's duration and counts with those of an undisturbed run.

// File: rtl/sdinit_pkg.sv
package sdinit_pkg;

  typedef enum logic [2:0] {
    CMD_NORMAL = 3'd0,
    CMD_NOP    = 3'd1,
    CMD_PREALL = 3'd2,
    CMD_MRS    = 3'd3,
    CMD_CBR    = 3'd4
  } cmd_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchCfg;
    logic loadStab;
    logic loadGap;
    logic rowClr;
    logic rowInc;
    logic refClr;
    logic refInc;
  } dpCtl_t;

  // status from datapath to control
  typedef struct packed {
    logic waitZero;
    logic rowLast;
    logic refLast;
    logic rowHit;
  } dpSts_t;

  // nanoseconds to whole clock cycles, rounded up, never below one
  function automatic int nsToCycles(input int ns, input int mhz);
    int c;
    c = (ns * mhz + 999) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/sdinit_dp.sv
module sdinit_dp
  import sdinit_pkg::*;
#(
  parameter int NUM_ROWS   = 4,
  parameter int REF_ROUNDS = 8,
  parameter int STAB_CYC   = 20000,
  parameter int NOP_CYC    = 200,
  parameter int TRP_CYC    = 2,
  parameter int TRC_CYC    = 7,
  parameter int MRS_CYC    = 2,
  parameter int WAIT_W     = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpCtl_t              ctl,
  input  cmd_e                step,
  input  logic [2:0]          casLat,
  input  logic [2:0]          burstLen,
  input  logic                burstType,
  input  logic                singleWrite,
  input  logic [NUM_ROWS-1:0] rowPresent,
  output dpSts_t              sts,
  output logic [11:0]         modeWord,
  output logic [NUM_ROWS-1:0] rowOneHot
);

  localparam int ROW_W = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1;
  localparam int REF_W = $clog2(REF_ROUNDS + 1);

  logic [WAIT_W-1:0] waitCnt, gapLoad;
  logic [ROW_W-1:0]  rowIdx;
  logic [REF_W-1:0]  refCnt;
  logic [2:0]        casReg, lenReg;
  logic              typeReg, singleReg;

  // recovery time that follows the step just issued
  always_comb begin
    case (step)
      CMD_NOP:    gapLoad = WAIT_W'(NOP_CYC - 1);
      CMD_PREALL: gapLoad = WAIT_W'(TRP_CYC - 1);
      CMD_CBR:    gapLoad = WAIT_W'(TRC_CYC - 1);
      CMD_MRS:    gapLoad = WAIT_W'(MRS_CYC - 1);
      default:    gapLoad = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  waitCnt <= '0;
    else if (ctl.loadStab)      waitCnt <= WAIT_W'(STAB_CYC - 1);
    else if (ctl.loadGap)       waitCnt <= gapLoad;
    else if (waitCnt != '0)     waitCnt <= waitCnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           rowIdx <= '0;
    else if (ctl.rowClr) rowIdx <= '0;
    else if (ctl.rowInc) rowIdx <= rowIdx + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           refCnt <= '0;
    else if (ctl.refClr) refCnt <= '0;
    else if (ctl.refInc) refCnt <= refCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      casReg    <= '0;
      lenReg    <= '0;
      typeReg   <= 1'b0;
      singleReg <= 1'b0;
    end else if (ctl.latchCfg) begin
      casReg    <= casLat;
      lenReg    <= burstLen;
      typeReg   <= burstType;
      singleReg <= singleWrite;
    end
  end

  assign modeWord = {2'b00, singleReg, 2'b00, casReg, typeReg, lenReg};

  for (genvar g = 0; g < NUM_ROWS; g++) begin : gRowDec
    assign rowOneHot[g] = (rowIdx == ROW_W'(g));
  end

  assign sts.waitZero = (waitCnt == '0);
  assign sts.rowLast  = (rowIdx == ROW_W'(NUM_ROWS - 1));
  assign sts.refLast  = (refCnt == REF_W'(REF_ROUNDS - 1));
  assign sts.rowHit   = rowPresent[rowIdx];

  // R3
  row_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(rowIdx) < NUM_ROWS);

  // R3
  ref_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(refCnt) < REF_ROUNDS);

endmodule

// File: rtl/sdinit_ctrl.sv
module sdinit_ctrl
  import sdinit_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic [2:0] casLat,
  input  dpSts_t     sts,
  output dpCtl_t     ctl,
  output cmd_e       step,
  output logic       issuing,
  output logic       refreshEn,
  output logic       done,
  output logic       cfgError
);

  typedef enum logic [2:0] {S_IDLE, S_STAB, S_ISSUE, S_GAP, S_NORM, S_DONE} state_e;

  state_e state, stateN;
  cmd_e   stepN;
  logic   errN, canStart, casOk;

  assign canStart = (state == S_IDLE) || (state == S_DONE);
  assign casOk    = (casLat == 3'd2) || (casLat == 3'd3);

  always_comb begin
    ctl    = '0;
    stateN = state;
    stepN  = step;
    errN   = cfgError;
    if (canStart && startPulse) begin
      if (casOk) begin
        ctl.latchCfg = 1'b1;
        ctl.loadStab = 1'b1;
        errN         = 1'b0;
        stepN        = CMD_NORMAL;
        stateN       = S_STAB;
      end else begin
        errN = 1'b1;
      end
    end else begin
      case (state)
        S_STAB: if (sts.waitZero) begin
          stepN      = CMD_NOP;
          ctl.rowClr = 1'b1;
          stateN     = S_ISSUE;
        end
        S_ISSUE: begin
          if (sts.rowLast) begin
            ctl.loadGap = 1'b1;
            stateN      = S_GAP;
          end else begin
            ctl.rowInc = 1'b1;
          end
        end
        S_GAP: if (sts.waitZero) begin
          ctl.rowClr = 1'b1;
          stateN     = S_ISSUE;
          case (step)
            CMD_NOP:    stepN = CMD_PREALL;
            CMD_PREALL: begin
              stepN      = CMD_CBR;
              ctl.refClr = 1'b1;
            end
            CMD_CBR: begin
              if (sts.refLast) stepN = CMD_MRS;
              else             ctl.refInc = 1'b1;
            end
            CMD_MRS: begin
              stepN  = CMD_NORMAL;
              stateN = S_NORM;
            end
            default: begin
              stepN  = CMD_NORMAL;
              stateN = S_IDLE;
            end
          endcase
        end
        S_NORM:  stateN = S_DONE;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      step     <= CMD_NORMAL;
      cfgError <= 1'b0;
    end else begin
      state    <= stateN;
      step     <= stepN;
      cfgError <= errN;
    end
  end

  assign issuing   = (state == S_ISSUE);
  assign refreshEn = (state == S_DONE);
  assign done      = (state == S_DONE);

  // R9
  bad_cas_chk: assert property (@(posedge clk) disable iff (!rstN)
    (canStart && startPulse && !casOk) |=> (cfgError && $stable(state)));

  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!canStart && startPulse) |=> (cfgError == $past(cfgError)));

  // R6
  refresh_after_normal_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(refreshEn) |-> ($past(state) == S_NORM && step == CMD_NORMAL));

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdinit_pkg::*;
#(
  parameter int NUM_ROWS   = 4,
  parameter int CLK_MHZ    = 100,
  parameter int STAB_US    = 200,
  parameter int NOP_CYC    = 200,
  parameter int TRP_NS     = 20,
  parameter int TRC_NS     = 70,
  parameter int MRS_CYC    = 2,
  parameter int REF_ROUNDS = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startPulse,
  input  logic [2:0]          casLat,
  input  logic [2:0]          burstLen,
  input  logic                burstType,
  input  logic                singleWrite,
  input  logic [NUM_ROWS-1:0] rowPresent,
  output logic [2:0]          cmdCode,
  output logic                cmdValid,
  output logic [NUM_ROWS-1:0] rowSel,
  output logic [11:0]         modeWord,
  output logic                refreshEn,
  output logic                done,
  output logic                cfgError
);

  localparam int STAB_CYC = STAB_US * CLK_MHZ;
  localparam int TRP_CYC  = nsToCycles(TRP_NS, CLK_MHZ);
  localparam int TRC_CYC  = nsToCycles(TRC_NS, CLK_MHZ);
  localparam int WAIT_W   = $clog2(STAB_CYC + NOP_CYC + TRP_CYC + TRC_CYC + MRS_CYC + 1);
  localparam int GAP_W    = WAIT_W + 1;

  dpCtl_t              ctl;
  dpSts_t              sts;
  cmd_e                step;
  logic                issuing;
  logic [NUM_ROWS-1:0] rowOneHot;

  sdinit_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .casLat(casLat),
    .sts(sts), .ctl(ctl), .step(step), .issuing(issuing),
    .refreshEn(refreshEn), .done(done), .cfgError(cfgError)
  );

  sdinit_dp #(
    .NUM_ROWS(NUM_ROWS), .REF_ROUNDS(REF_ROUNDS), .STAB_CYC(STAB_CYC),
    .NOP_CYC(NOP_CYC), .TRP_CYC(TRP_CYC), .TRC_CYC(TRC_CYC),
    .MRS_CYC(MRS_CYC), .WAIT_W(WAIT_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .step(step), .casLat(casLat),
    .burstLen(burstLen), .burstType(burstType), .singleWrite(singleWrite),
    .rowPresent(rowPresent), .sts(sts), .modeWord(modeWord), .rowOneHot(rowOneHot)
  );

  assign cmdCode  = step;
  assign cmdValid = issuing && sts.rowHit;
  assign rowSel   = cmdValid ? rowOneHot : '0;

  // spacing monitor between consecutive steps
  logic [GAP_W-1:0] sinceIss, reqGap;
  logic [2:0]       prevCode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceIss <= '0;
      prevCode <= CMD_NORMAL;
    end else if (cmdValid) begin
      sinceIss <= GAP_W'(1);
      prevCode <= cmdCode;
    end else if (sinceIss != '1) begin
      sinceIss <= sinceIss + 1'b1;
    end
  end

  always_comb begin
    case (prevCode)
      CMD_NOP:    reqGap = GAP_W'(NOP_CYC);
      CMD_PREALL: reqGap = GAP_W'(TRP_CYC);
      CMD_CBR:    reqGap = GAP_W'(TRC_CYC);
      default:    reqGap = '0;
    endcase
  end

  // R1
  code_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdCode <= 3'd4);

  // R3
  row_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> $onehot0(rowSel) && rowSel != '0);

  // R7
  empty_row_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> ((rowSel & ~rowPresent) == '0));

  // R6
  no_normal_issue_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> cmdCode != 3'd0);

  // R6
  refresh_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    refreshEn |-> (cmdCode == 3'd0 && !cmdValid));

  // R5
  mode_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdCode == 3'd3) |->
      (modeWord[6:4] inside {3'd2, 3'd3}) && modeWord[8:7] == 2'b00 && modeWord[11:10] == 2'b00);

  // R4
  step_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdCode != prevCode) |-> sinceIss >= reqGap);

endmodule

// File: tb/test_sdram_init_seq.sv
module test_sdram_init_seq;

  localparam int CLK_PERIOD = 10;
  localparam int ROWS   = 4;
  localparam int MHZ    = 100;
  localparam int STABUS = 20;
  // expected cycle figures, computed from the requirement formulas
  localparam int EXP_STAB = STABUS * MHZ;
  localparam int EXP_NOP  = 200;
  localparam int EXP_TRP  = 2;
  localparam int EXP_TRC  = 7;
  localparam int EXP_MRS  = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startPulse = 1'b0;
  logic [2:0] casLat = 3'd3;
  logic [2:0] burstLen = 3'd0;
  logic burstType = 1'b0;
  logic singleWrite = 1'b0;
  logic [ROWS-1:0] rowPresent = '1;
  logic [2:0] cmdCode;
  logic cmdValid;
  logic [ROWS-1:0] rowSel;
  logic [11:0] modeWord;
  logic refreshEn, done, cfgError;

  sdram_init_seq #(.NUM_ROWS(ROWS), .CLK_MHZ(MHZ), .STAB_US(STABUS)) i_sdram_init_seq (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .casLat(casLat),
    .burstLen(burstLen), .burstType(burstType), .singleWrite(singleWrite),
    .rowPresent(rowPresent), .cmdCode(cmdCode), .cmdValid(cmdValid),
    .rowSel(rowSel), .modeWord(modeWord), .refreshEn(refreshEn),
    .done(done), .cfgError(cfgError)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nChecks = 0;
  int nErr = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // issue log
  int cnt [5][ROWS];
  int seqIdx [ROWS];
  int lastCode [ROWS];
  int lastCyc [ROWS];
  int firstIss, lastMrs, totalIss;

  task automatic clearLog();
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < 5; c++) cnt[c][r] = 0;
      seqIdx[r] = 0;
      lastCode[r] = -1;
      lastCyc[r] = 0;
    end
    firstIss = -1;
    lastMrs = 0;
  endtask

  function automatic int expCode(input int idx);
    if (idx == 0) return 1;
    if (idx == 1) return 2;
    if (idx <= 9) return 4;
    return 3;
  endfunction

  function automatic int needGap(input int code);
    case (code)
      1: return EXP_NOP;
      2: return EXP_TRP;
      4: return EXP_TRC;
      default: return 0;
    endcase
  endfunction

  always @(negedge clk) begin
    if (rstN) begin
      if (cmdCode > 3'd4) check(1'b0, "R1", "reserved cmdCode", cmdCode, 4);
      if (refreshEn && (cmdValid || cmdCode != 3'd0))
        check(1'b0, "R6", "refreshEn with active bus", cmdCode, 0);
      if (cmdValid) begin
        int r;
        r = -1;
        totalIss++;
        if ($countones(rowSel) != 1) check(1'b0, "R3", "rowSel not one-hot", rowSel, 1);
        for (int k = 0; k < ROWS; k++) if (rowSel[k]) r = k;
        if (cmdCode == 3'd0) check(1'b0, "R6", "normal code issued", cmdCode, 1);
        if (r >= 0) begin
          if (!rowPresent[r]) check(1'b0, "R7", "issue to empty row", r, -1);
          if (firstIss < 0) firstIss = cyc;
          if (cmdCode == 3'd3) lastMrs = cyc;
          if (cmdCode <= 3'd4) cnt[cmdCode][r]++;
          if (seqIdx[r] > 10 || int'(cmdCode) != expCode(seqIdx[r]))
            check(1'b0, "R3", "order on row", cmdCode, expCode(seqIdx[r]));
          if (lastCode[r] >= 0 && (cyc - lastCyc[r]) < needGap(lastCode[r]))
            check(1'b0, "R4", "per-row gap", cyc - lastCyc[r], needGap(lastCode[r]));
          seqIdx[r]++;
          lastCode[r] = cmdCode;
          lastCyc[r] = cyc;
        end
      end
    end
  end

  // run one sequence; poke injects starts while busy
  task automatic runSeq(input logic [ROWS-1:0] rows, input logic [2:0] cas,
                        input logic [2:0] len, input bit typ, input bit single,
                        input logic [11:0] expMode, input bit poke, output int dur);
    int startCyc, n;
    @(negedge clk);
    rowPresent = rows; casLat = cas; burstLen = len; burstType = typ; singleWrite = single;
    clearLog();
    startPulse = 1'b1;
    startCyc = cyc;
    @(negedge clk);
    startPulse = 1'b0;
    check(cfgError == 1'b0, "R9", "cfgError cleared by accepted start", cfgError, 0);
    check(refreshEn == 1'b0, "R6", "refreshEn cleared by start", refreshEn, 0);
    n = 0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
      if (poke && (n == 100 || n == 2300)) begin
        startPulse = 1'b1; casLat = 3'd6;
      end else if (poke) begin
        startPulse = 1'b0; casLat = cas;
      end
    end
    startPulse = 1'b0;
    casLat = cas;
    dur = cyc - startCyc;
    check(done == 1'b1, "R6", "done reached", done, 1);
    check(refreshEn == 1'b1, "R6", "refreshEn at done", refreshEn, 1);
    check(cmdCode == 3'd0, "R6", "normal code at done", cmdCode, 0);
    check(cfgError == 1'b0, "R8", "cfgError after run", cfgError, 0);
    check(modeWord == expMode, "R5", "mode word", modeWord, expMode);
    check(firstIss - startCyc >= EXP_STAB, "R2", "stabilisation wait", firstIss - startCyc, EXP_STAB);
    check(cyc - lastMrs >= EXP_MRS, "R4", "MRS to normal gap", cyc - lastMrs, EXP_MRS);
    for (int r = 0; r < ROWS; r++) begin
      if (rows[r]) begin
        check(cnt[4][r] == 8, "R3", "refresh count per row", cnt[4][r], 8);
        check(seqIdx[r] == 11, "R3", "commands per row", seqIdx[r], 11);
      end else begin
        check(seqIdx[r] == 0, "R7", "empty row silent", seqIdx[r], 0);
      end
    end
    n = totalIss;
    repeat (20) @(negedge clk);
    check(refreshEn == 1'b1 && totalIss == n, "R6", "quiet after done", totalIss, n);
  endtask

  task automatic testReset();
    check(cmdCode == 3'd0, "R10", "reset cmdCode", cmdCode, 0);
    check(cmdValid == 1'b0 && rowSel == '0, "R10", "reset cmdValid/rowSel", rowSel, 0);
    check(refreshEn == 1'b0 && done == 1'b0, "R10", "reset refreshEn/done", done, 0);
    check(cfgError == 1'b0, "R10", "reset cfgError", cfgError, 0);
  endtask

  int baseDur;

  task automatic testFull();
    runSeq(4'b1111, 3'd3, 3'd3, 1'b0, 1'b0, 12'h033, 1'b0, baseDur);
  endtask

  task automatic testSparse();
    int d;
    runSeq(4'b1010, 3'd2, 3'd2, 1'b1, 1'b1, 12'h22A, 1'b0, d);
  endtask

  task automatic testBusyStart();
    int d;
    runSeq(4'b1111, 3'd3, 3'd3, 1'b0, 1'b0, 12'h033, 1'b1, d);
    check(d == baseDur, "R8", "duration with busy starts", d, baseDur);
  endtask

  task automatic testBadCas();
    int n;
    int d;
    @(negedge clk);
    n = totalIss;
    casLat = 3'd1;
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    check(cfgError == 1'b1, "R9", "cfgError from done state", cfgError, 1);
    repeat (50) @(negedge clk);
    check(done == 1'b1 && totalIss == n, "R9", "no restart on bad CAS", totalIss, n);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    casLat = 3'd7;
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    check(cfgError == 1'b1, "R9", "cfgError from idle", cfgError, 1);
    repeat (EXP_STAB + 500) @(negedge clk);
    check(done == 1'b0 && totalIss == n, "R9", "sequence not started", totalIss, n);
    runSeq(4'b0001, 3'd3, 3'd7, 1'b1, 1'b0, 12'h03F, 1'b0, d);
  endtask

  initial begin
    totalIss = 0;
    clearLog();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testFull();
    testSparse();
    testBusyStart();
    testBadCas();
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    check(1'b0, "WDOG", "watchdog expired", cyc, 0);
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule